// File: doc/BRIEF.md
# Timed Panel Power-Up Sequencer

This block brings a display panel up in a fixed order: panel supply, serial link (LVDS) driver, backlight supply, backlight PWM, and finally backlight enable. A start strobe runs the first (start) stage at once. Every later stage waits until a stored deadline has passed. Each of the first four stages sets the next deadline from its own delay, given in milliseconds and converted to microseconds. A prescaler inside the block divides the clock down to a microsecond count, which is the timebase for these deadlines.

There are two ways to advance. In blocking mode the sequencer steps by itself as soon as each deadline passes, and runs until done. In polled mode it steps only when a poll arrives at or after the deadline; an early poll does nothing. Four enable lines are optional, each with its own valid bit. A stage whose line is marked invalid leaves that output low, but its delay still counts. Enables stay set until reset.

Top module: `panel_pwrup_seq`

## Requirements
- R1: Enables rise in the order panel supply, LVDS, backlight supply, PWM, backlight enable. `done_o` rises in the same cycle as the backlight-enable stage runs.
- R2: After reset nothing moves until `start_i`. `advance_i` has no effect in the start stage. The start stage itself changes no output.
- R3: The delay of field k (`dly_ms_i[k*DLY_W +: DLY_W]`, k = 0..3) is applied after stage k: start, panel supply, LVDS, backlight supply. It is converted at 1000 µs per ms. With P = CLK_HZ/1e6 clocks per µs and D ≠ 0, the next stage runs between (1000·D−1)·P+1 and 1000·D·P cycles after stage k. With D = 0 it runs one cycle later in blocking mode.
- R4: The PWM stage and the backlight-enable stage add no delay. In blocking mode the backlight enable follows the PWM enable by exactly one cycle.
- R5: In blocking mode the sequencer reaches done with no `advance_i` activity.
- R6: In polled mode a poll before the deadline changes nothing. A poll at or after the deadline runs exactly one stage. Without a poll, nothing advances.
- R7: Valid bits in `line_valid_i`: bit 0 is panel supply, bit 1 is LVDS, bit 2 is backlight supply, bit 3 is backlight enable. A stage whose bit is 0 keeps its output low, and its timing still applies to the total time to done.
- R8: Once the PWM stage has run, `pwm_duty_o` is 0xDF, `pwm_rate_hz_o` is 32768 and `pwm_div_o` is 1. All three are 0 before that.
- R9: Once done, further `start_i` or `advance_i` pulses leave all outputs unchanged.
- R10: Every enable stays high once set, until `rst_ni` clears it. Reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Runs the start stage |
| advance_i | input | 1 | Poll request in polled mode |
| blocking_i | input | 1 | 1: self-advancing; 0: polled |
| dly_ms_i | input | 4*DLY_W | Four inter-stage delays in ms, field k at bits k*DLY_W |
| line_valid_i | input | 4 | Valid bits for the optional enable lines |
| panel_vdd_en_o | output | 1 | Panel supply enable |
| lvds_en_o | output | 1 | LVDS driver enable |
| bl_vdd_en_o | output | 1 | Backlight supply enable |
| pwm_en_o | output | 1 | Backlight PWM enable |
| pwm_duty_o | output | DUTY_W | PWM duty code |
| pwm_rate_hz_o | output | RATE_W | PWM rate in Hz |
| pwm_div_o | output | DIV_W | PWM divider |
| bl_en_o | output | 1 | Backlight enable |
| done_o | output | 1 | Sequence complete |

## Verification
The assertions assume that the inputs change only between clock edges. They also assume that the microsecond count never gets more than 2^31 µs ahead of a stored deadline, so the signed difference gives the right ordering. The stimulus drives every input at the falling edge and keeps delays to a few milliseconds. The clock-rate parameter is lowered so that each microsecond lasts two clocks. Random delays and valid masks are mixed with a directed polled run that places polls just before and just after each deadline.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_PANEL = 3'd1,
    ST_LVDS  = 3'd2,
    ST_BLVDD = 3'd3,
    ST_PWM   = 3'd4,
    ST_BLEN  = 3'd5,
    ST_DONE  = 3'd6
  } stage_e;

  localparam int unsigned N_TIMED   = 4;
  localparam int unsigned N_GATED   = 4;
  localparam int unsigned US_PER_MS = 1000;
endpackage

// File: rtl/pps_timebase.sv
module pps_timebase #(
  parameter int unsigned CLK_HZ = 200_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  output logic [31:0] now_us_o
);
  localparam int unsigned DIV = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int unsigned PW  = (DIV > 1) ? $clog2(DIV) : 1;

  logic tick;

  generate
    if (DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    pre_q <= '0;
        else if (pre_q == PW'(DIV - 1)) pre_q <= '0;
        else                            pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PW'(DIV - 1));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   now_us_o <= '0;
    else if (tick) now_us_o <= now_us_o + 32'd1;
  end

  // R3: timebase moves by at most one microsecond per clock
  p_us_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (now_us_o == $past(now_us_o)) || (now_us_o == $past(now_us_o) + 32'd1));
endmodule

// File: rtl/pps_deadline.sv
module pps_deadline
  import pps_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       arm_i,
  input  stage_e                     stage_i,
  input  logic [N_TIMED*DLY_W-1:0]   dly_ms_i,
  input  logic [31:0]                now_us_i,
  output logic                       reached_o
);
  localparam int unsigned SW = $clog2(N_TIMED);

  logic [DLY_W-1:0] dly_a [N_TIMED];
  logic [31:0]      add_us, dl_q, diff;
  logic [SW-1:0]    sel;

  for (genvar g = 0; g < N_TIMED; g++) begin : g_fld
    assign dly_a[g] = dly_ms_i[g*DLY_W +: DLY_W];
  end

  assign sel = stage_i[SW-1:0];

  always_comb begin
    add_us = '0;
    if (int'(stage_i) < N_TIMED) add_us = 32'(dly_a[sel]) * US_PER_MS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dl_q <= '0;
    else if (arm_i) dl_q <= now_us_i + add_us;
  end

  // wrap-safe: reached when (now - deadline) is non-negative as signed
  assign diff      = now_us_i - dl_q;
  assign reached_o = ~diff[31];

  // R4: stages from PWM onward add no wait
  p_no_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i && (stage_i == ST_PWM || stage_i == ST_BLEN) |=> reached_o);
endmodule

// File: rtl/pps_stage_fsm.sv
module pps_stage_fsm
  import pps_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   advance_i,
  input  logic   blocking_i,
  input  logic   reached_i,
  output stage_e stage_o,
  output logic   step_o
);
  stage_e stage_q;

  always_comb begin
    if (stage_q == ST_START)     step_o = start_i;
    else if (stage_q == ST_DONE) step_o = 1'b0;
    else                         step_o = reached_i && (blocking_i || advance_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= ST_START;
    else if (step_o) stage_q <= stage_e'(stage_q + 3'd1);
  end

  assign stage_o = stage_q;

  p_start_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == ST_START && !start_i |=> stage_q == ST_START);
  p_early_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q != ST_START && !reached_i |=> $stable(stage_q));
  p_poll_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q != ST_START && !blocking_i && !advance_i |=> $stable(stage_q));
  p_done_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q == ST_DONE |=> stage_q == ST_DONE);
endmodule

// File: rtl/pps_out_regs.sv
module pps_out_regs
  import pps_pkg::*;
#(
  parameter int unsigned DUTY_W      = 8,
  parameter int unsigned RATE_W      = 16,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned PWM_DUTY    = 8'hDF,
  parameter int unsigned PWM_RATE_HZ = 32768,
  parameter int unsigned PWM_DIV     = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  stage_e             stage_i,
  input  logic [N_GATED-1:0] valid_i,
  output logic [N_GATED-1:0] en_o,
  output logic               pwm_en_o,
  output logic [DUTY_W-1:0]  pwm_duty_o,
  output logic [RATE_W-1:0]  pwm_rate_hz_o,
  output logic [DIV_W-1:0]   pwm_div_o
);
  // gated line g: 0 panel supply, 1 LVDS, 2 backlight supply, 3 backlight enable
  for (genvar g = 0; g < N_GATED; g++) begin : g_line
    localparam stage_e OWN = (g == 0) ? ST_PANEL :
                             (g == 1) ? ST_LVDS  :
                             (g == 2) ? ST_BLVDD : ST_BLEN;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  en_o[g] <= 1'b0;
      else if (step_i && stage_i == OWN && valid_i[g]) en_o[g] <= 1'b1;
    end

    p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[g] |=> en_o[g]);
    p_masked_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_o[g] && !valid_i[g] |=> !en_o[g]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           pwm_en_o <= 1'b0;
    else if (step_i && stage_i == ST_PWM)  pwm_en_o <= 1'b1;
  end

  assign pwm_duty_o    = pwm_en_o ? DUTY_W'(PWM_DUTY)    : '0;
  assign pwm_rate_hz_o = pwm_en_o ? RATE_W'(PWM_RATE_HZ) : '0;
  assign pwm_div_o     = pwm_en_o ? DIV_W'(PWM_DIV)      : '0;

  p_pwm_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_en_o |=> pwm_en_o);
endmodule

// File: rtl/panel_pwrup_seq.sv
module panel_pwrup_seq
  import pps_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 200_000_000,
  parameter int unsigned DLY_W       = 8,
  parameter int unsigned DUTY_W      = 8,
  parameter int unsigned RATE_W      = 16,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned PWM_DUTY    = 8'hDF,
  parameter int unsigned PWM_RATE_HZ = 32768,
  parameter int unsigned PWM_DIV     = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     advance_i,
  input  logic                     blocking_i,
  input  logic [N_TIMED*DLY_W-1:0] dly_ms_i,
  input  logic [N_GATED-1:0]       line_valid_i,
  output logic                     panel_vdd_en_o,
  output logic                     lvds_en_o,
  output logic                     bl_vdd_en_o,
  output logic                     pwm_en_o,
  output logic [DUTY_W-1:0]        pwm_duty_o,
  output logic [RATE_W-1:0]        pwm_rate_hz_o,
  output logic [DIV_W-1:0]         pwm_div_o,
  output logic                     bl_en_o,
  output logic                     done_o
);
  logic [31:0]        now_us;
  logic               reached, step;
  stage_e             stage;
  logic [N_GATED-1:0] en;

  pps_timebase #(.CLK_HZ(CLK_HZ)) u_tb (
    .clk_i(clk_i), .rst_ni(rst_ni), .now_us_o(now_us)
  );

  pps_deadline #(.DLY_W(DLY_W)) u_dl (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(step), .stage_i(stage),
    .dly_ms_i(dly_ms_i), .now_us_i(now_us), .reached_o(reached)
  );

  pps_stage_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .advance_i(advance_i),
    .blocking_i(blocking_i), .reached_i(reached), .stage_o(stage), .step_o(step)
  );

  pps_out_regs #(
    .DUTY_W(DUTY_W), .RATE_W(RATE_W), .DIV_W(DIV_W),
    .PWM_DUTY(PWM_DUTY), .PWM_RATE_HZ(PWM_RATE_HZ), .PWM_DIV(PWM_DIV)
  ) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step), .stage_i(stage),
    .valid_i(line_valid_i), .en_o(en), .pwm_en_o(pwm_en_o),
    .pwm_duty_o(pwm_duty_o), .pwm_rate_hz_o(pwm_rate_hz_o), .pwm_div_o(pwm_div_o)
  );

  assign panel_vdd_en_o = en[0];
  assign lvds_en_o      = en[1];
  assign bl_vdd_en_o    = en[2];
  assign bl_en_o        = en[3];
  assign done_o         = (stage == ST_DONE);

  p_order_pwm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> !done_o && !bl_en_o);
  p_order_blen_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bl_en_o) |-> pwm_en_o && done_o);
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(pwm_en_o));
endmodule

// File: tb/panel_pwrup_seq_bench.sv
module panel_pwrup_seq_bench;
  localparam int P      = 2;
  localparam int CLK_HZ = P * 1_000_000;
  localparam int DLY_W  = 4;
  localparam int LIMIT  = 190_000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, advance_i = 1'b0, blocking_i = 1'b0;
  logic [4*DLY_W-1:0] dly_ms_i = '0;
  logic [3:0] line_valid_i = 4'hF;
  logic panel_vdd_en_o, lvds_en_o, bl_vdd_en_o, pwm_en_o, bl_en_o, done_o;
  logic [7:0]  pwm_duty_o;
  logic [15:0] pwm_rate_hz_o;
  logic [3:0]  pwm_div_o;

  int cyc = 0, n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  panel_pwrup_seq #(.CLK_HZ(CLK_HZ), .DLY_W(DLY_W)) u_panel_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .advance_i(advance_i),
    .blocking_i(blocking_i), .dly_ms_i(dly_ms_i), .line_valid_i(line_valid_i),
    .panel_vdd_en_o(panel_vdd_en_o), .lvds_en_o(lvds_en_o), .bl_vdd_en_o(bl_vdd_en_o),
    .pwm_en_o(pwm_en_o), .pwm_duty_o(pwm_duty_o), .pwm_rate_hz_o(pwm_rate_hz_o),
    .pwm_div_o(pwm_div_o), .bl_en_o(bl_en_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int win_lo(input int d);
    return (d == 0) ? 1 : (d * 1000 - 1) * P + 1;
  endfunction
  function automatic int win_hi(input int d);
    return (d == 0) ? 1 : d * 1000 * P;
  endfunction

  function automatic int outs();
    return {26'd0, panel_vdd_en_o, lvds_en_o, bl_vdd_en_o, pwm_en_o, bl_en_o, done_o};
  endfunction

  always @(posedge clk) if (cyc == LIMIT) begin
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0; start_i = 1'b0; advance_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(outs() == 0, "R10 reset outputs", outs(), 0);
    chk(pwm_duty_o == 0 && pwm_rate_hz_o == 0 && pwm_div_o == 0, "R8 pwm zero at reset",
        int'(pwm_duty_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic poll();
    advance_i = 1'b1; @(negedge clk); advance_i = 1'b0;
  endtask

  task automatic run_block(input int d0, input int d1, input int d2, input int d3,
                           input logic [3:0] mask);
    int t0, tp, tl, tb, tw, te, td, lo, hi, snap;
    tp = -1; tl = -1; tb = -1; tw = -1; te = -1; td = -1;
    do_reset();
    dly_ms_i = {DLY_W'(d3), DLY_W'(d2), DLY_W'(d1), DLY_W'(d0)};
    line_valid_i = mask; blocking_i = 1'b1;
    pulse_start();
    t0 = cyc;
    chk(outs() == 0, "R2 start stage drives nothing", outs(), 0);
    for (int i = 0; i < 20000 && td < 0; i++) begin
      if (panel_vdd_en_o && tp < 0) tp = cyc;
      if (lvds_en_o && tl < 0)      tl = cyc;
      if (bl_vdd_en_o && tb < 0)    tb = cyc;
      if (pwm_en_o && tw < 0)       tw = cyc;
      if (bl_en_o && te < 0)        te = cyc;
      if (done_o && td < 0)         td = cyc;
      if (td < 0) @(negedge clk);
    end
    chk(td >= 0, "R5 blocking run reaches done", td, 1);
    if (mask == 4'hF) begin
      chk(tp - t0 >= win_lo(d0) && tp - t0 <= win_hi(d0), "R3 delay after start", tp - t0, win_lo(d0));
      chk(tl - tp >= win_lo(d1) && tl - tp <= win_hi(d1), "R3 delay after panel", tl - tp, win_lo(d1));
      chk(tb - tl >= win_lo(d2) && tb - tl <= win_hi(d2), "R3 delay after lvds", tb - tl, win_lo(d2));
      chk(tw - tb >= win_lo(d3) && tw - tb <= win_hi(d3), "R3 delay after bl supply", tw - tb, win_lo(d3));
      chk(te - tw == 1, "R4 bl enable one cycle after pwm", te - tw, 1);
      chk(tp < tl && tl < tb && tb < tw && tw < te && te == td, "R1 stage order", td, te);
    end else begin
      lo = win_lo(d0) + win_lo(d1) + win_lo(d2) + win_lo(d3) + 1;
      hi = win_hi(d0) + win_hi(d1) + win_hi(d2) + win_hi(d3) + 1;
      chk(td - t0 >= lo && td - t0 <= hi, "R7 masked stage timing kept", td - t0, lo);
      chk(panel_vdd_en_o == mask[0] && lvds_en_o == mask[1] && bl_vdd_en_o == mask[2]
          && bl_en_o == mask[3], "R7 masked lines stay low",
          int'({panel_vdd_en_o, lvds_en_o, bl_vdd_en_o, bl_en_o}),
          int'({mask[0], mask[1], mask[2], mask[3]}));
      chk(pwm_en_o == 1'b1, "R1 pwm stage unmasked", int'(pwm_en_o), 1);
    end
    chk(pwm_duty_o == 8'hDF && pwm_rate_hz_o == 16'd32768 && pwm_div_o == 4'd1,
        "R8 pwm settings", int'(pwm_duty_o), 'hDF);
    snap = outs();
    pulse_start(); poll(); repeat (5) @(negedge clk);
    chk(outs() == snap, "R9 done ignores pulses", outs(), snap);
  endtask

  task automatic run_polled();
    int t0;
    do_reset();
    dly_ms_i = {DLY_W'(0), DLY_W'(2), DLY_W'(0), DLY_W'(1)};
    line_valid_i = 4'hF; blocking_i = 1'b0;
    poll(); repeat (3) @(negedge clk);
    chk(outs() == 0, "R2 advance ignored before start", outs(), 0);
    blocking_i = 1'b1; poll(); repeat (3) @(negedge clk); blocking_i = 1'b0;
    chk(outs() == 0, "R2 blocking idle before start", outs(), 0);
    pulse_start(); t0 = cyc;
    poll();
    chk(panel_vdd_en_o == 1'b0, "R6 early poll ignored", int'(panel_vdd_en_o), 0);
    while (cyc < t0 + 1000) @(negedge clk);
    poll();
    chk(panel_vdd_en_o == 1'b0, "R6 mid-wait poll ignored", int'(panel_vdd_en_o), 0);
    while (cyc < t0 + 2100) @(negedge clk);
    chk(panel_vdd_en_o == 1'b0, "R6 no poll no step", int'(panel_vdd_en_o), 0);
    poll();
    chk(panel_vdd_en_o == 1'b1 && lvds_en_o == 1'b0, "R6 late poll one stage",
        int'({panel_vdd_en_o, lvds_en_o}), 2);
    repeat (50) @(negedge clk);
    chk(lvds_en_o == 1'b0, "R6 zero delay still needs poll", int'(lvds_en_o), 0);
    poll();
    chk(lvds_en_o == 1'b1, "R6 lvds on poll", int'(lvds_en_o), 1);
    t0 = cyc;
    poll();
    chk(bl_vdd_en_o == 1'b0, "R6 poll before 2 ms", int'(bl_vdd_en_o), 0);
    while (cyc < t0 + 4100) @(negedge clk);
    poll();
    chk(bl_vdd_en_o == 1'b1 && pwm_en_o == 1'b0, "R6 bl supply on poll",
        int'({bl_vdd_en_o, pwm_en_o}), 2);
    poll();
    chk(pwm_en_o == 1'b1 && bl_en_o == 1'b0, "R6 pwm on poll", int'({pwm_en_o, bl_en_o}), 2);
    poll();
    chk(bl_en_o == 1'b1 && done_o == 1'b1, "R1 bl enable and done together",
        int'({bl_en_o, done_o}), 3);
  endtask

  initial begin
    int seed_ret;
    seed_ret = $urandom(32'h5EED_0042);
    run_block(0, 0, 0, 0, 4'hF);
    run_block(1, 2, 0, 1, 4'hF);
    run_polled();
    run_block(2, 0, 1, 0, 4'b0101);
    for (int r = 0; r < 3; r++) begin
      int a, b, c, d;
      logic [3:0] m;
      a = int'($urandom % 3); b = int'($urandom % 3);
      c = int'($urandom % 2); d = int'($urandom % 2);
      m = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
      run_block(a, b, c, d, m);
    end
    do_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule